// File: doc/BRIEF.md
# Delay Calibration Saturating Controller

This controller tunes the 4-bit control code of a digitally adjustable delay line. The aim is to make a delayed data path match the latency of an oscillator phase-reset path. Calibration begins with a start pulse, and the code is loaded at mid-scale. On each update strobe the controller reads a one-bit early/late decision from the phase detector's edge sampler. It then moves the code one step up or down, and the code holds at its end values.

As the two delays come close to matching, the decision begins to alternate and the running code wanders around the match point. The controller counts the reversals of the decision. Once enough reversals have been seen, the next falling decision freezes the code and raises a done flag. A single noisy flip is therefore not enough to end the run.

An override select can replace the calibrated code at the output with an externally supplied value. Calibration carries on underneath the override.

Top module: `dcal_ctrl`

## Requirements
- R1: Reset leaves the running code at mid-scale 8 and done low. Update strobes have no effect on the code before the first calibration start.
- R2: During calibration, a strobe with decision 1 raises the code by one and a strobe with decision 0 lowers it by one. Cycles without a strobe leave the code unchanged.
- R3: The code stops at 15 and at 0. It never wraps.
- R4: A reversal is a strobe whose decision differs from the previous strobe's decision in the same run. Done cannot rise before 2 reversals have been counted, so a single reversal leaves calibration running.
- R5: Done rises at the strobe where the decision falls from 1 to 0, if that strobe brings the reversal count to at least 2. The code is frozen at the value it held before that strobe, with no step applied.
- R6: While done is high, strobes and decisions leave both the code and done unchanged.
- R7: A calibration start, in any state, reloads the code to 8, clears done and clears the decision history. The first strobe after a start is never a reversal.
- R8: While the override select is 1, the code output equals the 4-bit override input. Calibration keeps running underneath, and the calibrated code reappears when the select returns to 0.
- R9: A reversal from 0 to 1 never ends calibration, even when the reversal count is already 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_start | input | 1 | Starts or restarts calibration (single-cycle pulse) |
| upd_stb | input | 1 | Update strobe; the decision is used only when this is 1 |
| dec | input | 1 | Early/late decision: 1 means increase the delay |
| ovr_sel | input | 1 | 1 selects the override code at the output |
| ovr_code | input | 4 | External override code |
| code_o | output | 4 | Delay-line code |
| done_o | output | 1 | Calibration has converged and the code is frozen |

## Verification
The assertions take it that `cal_start` and `upd_stb` are synchronous to `clk` and that `dec` is meaningful only in strobe cycles. They also take it that a start has priority over a strobe in the same cycle. The bench changes every input on the falling clock edge. Its random runs steer the decision toward a random target code with occasional flipped samples, so they reach saturation, single reversals and convergence. Strobes, starts and override changes are mixed in at random cycles.

// File: rtl/dcal_pkg.sv
package dcal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_RUN  = 2'd1,
    CAL_HOLD = 2'd2
  } cal_state_e;

  // One saturating step of the code toward up/down, bounded by [0, top].
  function automatic int unsigned sat_step(int unsigned cur, logic up, int unsigned top);
    if (up) return (cur >= top) ? top : cur + 1;
    else    return (cur == 0)   ? 0   : cur - 1;
  endfunction

  // Reversal counter update, saturating at lim.
  function automatic int unsigned rev_next(int unsigned cnt, logic flip, int unsigned lim);
    if (!flip)      return cnt;
    if (cnt >= lim) return lim;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/dcal_stepper.sv
module dcal_stepper #(
  parameter int CODE_W    = 4,
  parameter int INIT_CODE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              up,
  output logic [CODE_W-1:0] code
);
  import dcal_pkg::*;

  localparam int unsigned TOP = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] INIT = CODE_W'(INIT_CODE);

  logic [CODE_W-1:0] code_nx;

  always_comb begin
    code_nx = code;
    if (load)      code_nx = INIT;
    else if (step) code_nx = CODE_W'(sat_step(int'(code), up, TOP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= INIT;
    else        code <= code_nx;
  end
endmodule

// File: rtl/dcal_toggle.sv
module dcal_toggle #(
  parameter int REV_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  input  logic dec,
  output logic fall_qual
);
  import dcal_pkg::*;

  localparam int REV_W = $clog2(REV_MIN + 1);

  logic             prev_dec;
  logic             have_prev;
  logic [REV_W-1:0] rev_cnt;
  logic             flip;
  logic [REV_W-1:0] rev_nx;

  assign flip      = have_prev && (prev_dec != dec);
  assign rev_nx    = REV_W'(rev_next(int'(rev_cnt), flip, REV_MIN));
  assign fall_qual = have_prev && prev_dec && !dec && (int'(rev_nx) >= REV_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dec  <= 1'b0;
      have_prev <= 1'b0;
      rev_cnt   <= '0;
    end else if (clear) begin
      prev_dec  <= 1'b0;
      have_prev <= 1'b0;
      rev_cnt   <= '0;
    end else if (sample) begin
      prev_dec  <= dec;
      have_prev <= 1'b1;
      rev_cnt   <= rev_nx;
    end
  end
endmodule

// File: rtl/dcal_seq.sv
module dcal_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic freeze,
  output logic running,
  output logic holding
);
  import dcal_pkg::*;

  cal_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (start)                          st_nx = CAL_RUN;
    else if (st == CAL_RUN && freeze)   st_nx = CAL_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= CAL_IDLE;
    else        st <= st_nx;
  end

  assign running = (st == CAL_RUN);
  assign holding = (st == CAL_HOLD);
endmodule

// File: rtl/dcal_ctrl.sv
module dcal_ctrl #(
  parameter int CODE_W  = 4,
  parameter int REV_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic              upd_stb,
  input  logic              dec,
  input  logic              ovr_sel,
  input  logic [CODE_W-1:0] ovr_code,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int INIT_CODE = 1 << (CODE_W - 1);

  logic              running;
  logic              holding;
  logic              sample_ev;
  logic              fall_qual;
  logic              freeze_ev;
  logic              step_en;
  logic [CODE_W-1:0] run_code;

  assign sample_ev = upd_stb && running && !cal_start;
  assign freeze_ev = sample_ev && fall_qual;
  assign step_en   = sample_ev && !fall_qual;

  dcal_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cal_start),
    .freeze  (freeze_ev),
    .running (running),
    .holding (holding)
  );

  dcal_toggle #(.REV_MIN(REV_MIN)) u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cal_start),
    .sample    (sample_ev),
    .dec       (dec),
    .fall_qual (fall_qual)
  );

  dcal_stepper #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cal_start),
    .step  (step_en),
    .up    (dec),
    .code  (run_code)
  );

  assign done_o = holding;
  assign code_o = ovr_sel ? ovr_code : run_code;
endmodule

// File: rtl/dcal_ctrl_chk.sv
module dcal_ctrl_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start,
  input logic              upd_stb,
  input logic              dec,
  input logic              step_en,
  input logic [CODE_W-1:0] run_code,
  input logic              done_o
);
  localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MIDC = CODE_W'(1 << (CODE_W - 1));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && dec && run_code != MAXC |=> run_code == CODE_W'($past(run_code) + 1'b1));
  // R2
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !dec && run_code != '0 |=> run_code == CODE_W'($past(run_code) - 1'b1));
  // R3
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && dec && run_code == MAXC |=> run_code == MAXC);
  // R3
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !dec && run_code == '0 |=> run_code == '0);
  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb && !cal_start |=> $stable(run_code));
  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(upd_stb) && !$past(dec) && $stable(run_code));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !cal_start |=> done_o && $stable(run_code));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> run_code == MIDC && !done_o);
endmodule

bind dcal_ctrl dcal_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cal_start (cal_start),
  .upd_stb   (upd_stb),
  .dec       (dec),
  .step_en   (step_en),
  .run_code  (run_code),
  .done_o    (done_o)
);

// File: tb/dcal_ctrl_test.sv
module dcal_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_start = 1'b0;
  logic       upd_stb = 1'b0;
  logic       dec = 1'b0;
  logic       ovr_sel = 1'b0;
  logic [3:0] ovr_code = 4'd0;
  logic [3:0] code_o;
  logic       done_o;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  // bench model state
  int m_code = 8;
  bit m_done = 0;
  bit m_run  = 0;
  bit m_have = 0;
  bit m_prev = 0;
  int m_rev  = 0;

  dcal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .upd_stb(upd_stb),
    .dec(dec), .ovr_sel(ovr_sel), .ovr_code(ovr_code),
    .code_o(code_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  function automatic int clamp16(int v);
    return (v < 0) ? 0 : ((v > 15) ? 15 : v);
  endfunction

  function automatic int exp_out(bit osel, int ocode, int mc);
    return osel ? ocode : mc;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(bit st, bit stb, bit d);
    if (st) begin
      m_code = 8; m_done = 0; m_run = 1; m_have = 0; m_rev = 0;
    end else if (stb && m_run) begin
      int revn = m_rev;
      if (m_have && (m_prev != d) && revn < 2) revn++;
      if (m_have && m_prev && !d && revn >= 2) begin
        m_done = 1; m_run = 0;
      end else begin
        m_code = clamp16(m_code + (d ? 1 : -1));
      end
      m_prev = d; m_have = 1; m_rev = revn;
    end
  endtask

  task automatic cyc(bit st, bit stb, bit d, bit osel, int oc, string tag);
    @(negedge clk);
    cal_start = st; upd_stb = stb; dec = d; ovr_sel = osel; ovr_code = 4'(oc);
    @(posedge clk);
    model_edge(st, stb, d);
    #2;
    check(tag, int'(code_o), exp_out(osel, oc, m_code), "code");
    check(tag, int'(done_o), int'(m_done), "done");
  endtask

  task automatic strobe(bit d, string tag);
    cyc(0, 1, d, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    #12;
    check("R1", int'(code_o), 8, "reset code");
    check("R1", int'(done_o), 0, "reset done");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: strobes before any start are ignored
    strobe(1, "R1"); strobe(1, "R1"); strobe(0, "R1");
    check("R1", int'(code_o), 8, "idle code");
    // R2 and R3: up to saturation at 15
    cyc(1, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 10; i++) strobe(1, "R3");
    check("R3", int'(code_o), 15, "sat high");
    cyc(0, 0, 1, 0, 0, "R2");
    // R3: down to 0 and stay (no reversal needed: dec stays 0 after one flip)
    cyc(1, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 12; i++) strobe(0, "R3");
    check("R3", int'(code_o), 0, "sat low");
    // R4: one reversal does not finish
    cyc(1, 0, 0, 0, 0, "R7");
    strobe(1, "R4"); strobe(0, "R4");
    check("R4", int'(done_o), 0, "single reversal");
    check("R4", int'(code_o), 8, "single reversal code");
    // R9: rising reversal with count 2 does not finish
    strobe(1, "R9");
    check("R9", int'(done_o), 0, "rising reversal");
    strobe(1, "R9");
    check("R9", int'(code_o), 10, "code after rise");
    // R5: falling reversal finishes, code frozen at 10
    strobe(0, "R5");
    check("R5", int'(done_o), 1, "done on fall");
    check("R5", int'(code_o), 10, "frozen code");
    // R6: strobes after done ignored
    strobe(0, "R6"); strobe(1, "R6"); strobe(0, "R6");
    check("R6", int'(code_o), 10, "hold code");
    check("R6", int'(done_o), 1, "hold done");
    // R8: override while done and while running
    cyc(0, 0, 0, 1, 3, "R8");
    check("R8", int'(code_o), 3, "override");
    cyc(0, 0, 0, 0, 3, "R8");
    check("R8", int'(code_o), 10, "override released");
    // R7: restart clears history; first strobe is not a reversal
    cyc(1, 0, 0, 0, 0, "R7");
    check("R7", int'(done_o), 0, "restart done");
    strobe(0, "R7");
    check("R7", int'(code_o), 7, "first strobe after start");
    cyc(0, 1, 1, 1, 12, "R8");
    cyc(0, 0, 1, 0, 12, "R8");
    check("R8", int'(code_o), 8, "calibration ran under override");

    // random runs steered toward a target code
    for (int run = 0; run < 300; run++) begin
      int target = int'($urandom % 16);
      cyc(1, 0, 0, 0, 0, "R7");
      for (int k = 0; k < 80 && !m_done; k++) begin
        bit stb  = ($urandom % 10) < 7;
        bit d    = (m_code < target) || (m_code == target && ($urandom % 2) == 1);
        bit osel = ($urandom % 10) == 0;
        if (($urandom % 8) == 0) d = ~d;
        cyc(0, stb, d, osel, int'($urandom % 16), "R2");
      end
      for (int k = 0; k < 3; k++)
        cyc(0, 1, 1'($urandom % 2), 0, 0, "R6");
    end

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule